// File: doc/BRIEF.md
# Dual-Bank Live ROM Emulator Controller

This block stands in for a 32 KB byte-wide parallel ROM attached to a running target microcontroller. Two external SRAM chips hold two copies of the image. One bank is active and answers target fetches. The other bank is the shadow, and the host loads it one byte at a time. The target read path is purely combinational, from the address and the two active-low enables through the active SRAM to the data pins. The access time therefore comes from the SRAM alone, about 45 ns, which stays inside the target's 90 ns window.

The host side is a plain parallel port. It carries a write strobe, a read-back strobe and a swap request, and a ready flag paces each operation. A write holds the shadow write-enable low for a fixed number of clocks, then spends one recovery clock with the address held. A read-back lets the host verify a loaded image before it is committed. A swap request stays pending until two conditions hold: the host engine is idle, and the synchronized target enables show no fetch in progress. The roles then flip on a single clock edge, and a one-cycle done pulse follows.

Top module: `rom_emu_ctrl`

## Requirements
- R1: After reset, active_bank_o is 0 (bank 0 active, bank 1 shadow), host_ready_o is 1, and swap_done_o and host_rvalid_o are 0.
- R2: While tgt_ce_ni and tgt_oe_ni are both low, tgt_data_o equals the byte at tgt_addr_i in the active bank, with no clock edge in the path.
- R3: tgt_drive_o, the pad enable for the target data bus, is 1 only while both tgt_ce_ni and tgt_oe_ni are 0. At all other times it is 0 (bus high-impedance) and tgt_data_o is 0.
- R4: The active bank's SRAM address equals tgt_addr_i, its chip enable and output enable follow tgt_ce_ni and tgt_oe_ni, and its write enable is always high.
- R5: A write is accepted when host_wr_i is 1 at a clock edge with host_ready_o at 1. From the next cycle, the shadow write enable is low for WR_PULSE cycles and then high for one recovery cycle, with the shadow chip enable low and the address and data held throughout. host_ready_o is 0 for those WR_PULSE+1 cycles. A strobe seen while host_ready_o is 0 is ignored.
- R6: A read-back is accepted when host_rd_i is 1, host_wr_i is 0 and host_ready_o is 1 at an edge. The shadow output enable and chip enable are then low for RD_WAIT cycles. In the next cycle, host_rvalid_o is 1 for exactly one cycle and host_rdata_o holds the shadow byte at the requested address. If both strobes are high together, the write wins.
- R7: host_swap_i at an edge makes a swap pending. While a swap is pending, host_ready_o is 0.
- R8: A pending swap executes at the first edge at which the host engine is idle and the target idle state (tgt_ce_ni or tgt_oe_ni high), as sampled SYNC_STAGES edges earlier, is true. A target that keeps both enables low holds the swap off indefinitely.
- R9: On a swap, active_bank_o toggles at that edge, the SRAM roles of the two banks exchange, and swap_done_o is 1 for the following cycle only.
- R10: While no host operation is in progress, the shadow bank's chip enable, output enable and write enable are all high.
- R11: Further requests while a swap is pending merge into that one swap. A request at the very edge a swap executes is kept pending for a later swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tgt_addr_i | input | ADDR_W | Target fetch address |
| tgt_ce_ni | input | 1 | Target chip enable, active low |
| tgt_oe_ni | input | 1 | Target output enable, active low |
| tgt_data_o | output | DATA_W | Byte returned to target |
| tgt_drive_o | output | 1 | Target data pad enable (0 = high-impedance) |
| host_addr_i | input | ADDR_W | Host byte address in shadow bank |
| host_wdata_i | input | DATA_W | Host write byte |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read-back strobe |
| host_swap_i | input | 1 | Host bank swap request |
| host_ready_o | output | 1 | Next host operation can be accepted |
| host_rdata_o | output | DATA_W | Read-back byte |
| host_rvalid_o | output | 1 | host_rdata_o valid, one cycle |
| swap_done_o | output | 1 | Swap executed, one-cycle pulse |
| active_bank_o | output | 1 | Index of the bank serving the target |
| sram_addr_o | output | 2 x ADDR_W | Address per bank |
| sram_wdata_o | output | 2 x DATA_W | Write data per bank |
| sram_rdata_i | input | 2 x DATA_W | Read data per bank |
| sram_ce_no | output | 2 | Chip enable per bank, active low |
| sram_oe_no | output | 2 | Output enable per bank, active low |
| sram_we_no | output | 2 | Write enable per bank, active low |

## Verification
The bench builds the block with ADDR_W=8, WR_PULSE=3, RD_WAIT=2 and SYNC_STAGES=2. Each SRAM is then small enough to model in full, so the bench can address every byte, and the first and last addresses are easy to reach. Short pulse and wait counts keep each host operation to a few cycles. Swap requests can then collide with writes, read-backs, fetch bursts and repeat requests many times within a few thousand cycles. With two synchronizer stages, the deferral of a swap behind a fetch that has just ended is exactly two edges.

// File: rtl/rom_emu_pkg.sv
package rom_emu_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_WR,
    ENG_REC,
    ENG_RD
  } eng_state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
  } sram_ctl_t;

  localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/rom_emu_sync.sv
module rom_emu_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/rom_emu_host_eng.sv
module rom_emu_host_eng
  import rom_emu_pkg::*;
#(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned WR_PULSE = 3,
  parameter int unsigned RD_WAIT  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] sh_rdata_i,
  output logic              idle_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] sh_addr_o,
  output logic [DATA_W-1:0] sh_wdata_o,
  output sram_ctl_t         sh_ctl_o
);

  localparam int unsigned MAX_C = (WR_PULSE > RD_WAIT) ? WR_PULSE : RD_WAIT;
  localparam int unsigned CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  eng_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              wr_acc, rd_acc, cnt_zero;

  assign idle_o   = (state_q == ENG_IDLE);
  assign ready_o  = idle_o && !hold_i;
  assign wr_acc   = ready_o && wr_i;
  assign rd_acc   = ready_o && rd_i && !wr_i;
  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ENG_IDLE;
      cnt_q    <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (state_q)
        ENG_IDLE: begin
          if (wr_acc) begin
            state_q <= ENG_WR;
            cnt_q   <= CNT_W'(WR_PULSE - 1);
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
          end else if (rd_acc) begin
            state_q <= ENG_RD;
            cnt_q   <= CNT_W'(RD_WAIT - 1);
            addr_q  <= addr_i;
          end
        end
        ENG_WR: begin
          if (cnt_zero) state_q <= ENG_REC;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        ENG_REC: state_q <= ENG_IDLE;
        ENG_RD: begin
          if (cnt_zero) begin
            state_q  <= ENG_IDLE;
            rdata_q  <= sh_rdata_i;
            rvalid_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  // chip enable spans the recovery cycle so the write edge sees a selected chip
  assign sh_ctl_o.ce_n = idle_o;
  assign sh_ctl_o.we_n = (state_q != ENG_WR);
  assign sh_ctl_o.oe_n = (state_q != ENG_RD);
  assign sh_addr_o     = addr_q;
  assign sh_wdata_o    = wdata_q;
  assign rdata_o       = rdata_q;
  assign rvalid_o      = rvalid_q;

  generate
    if (WR_PULSE > 1) begin : g_pw_chk
      assert_we_pulse_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sh_ctl_o.we_n) |=> !sh_ctl_o.we_n);
    end
  endgenerate

  assert_we_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sh_ctl_o.we_n) |-> ($stable(sh_addr_o) && $stable(sh_wdata_o) && !sh_ctl_o.ce_n));

  assert_rvalid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

endmodule

// File: rtl/rom_emu_bank_sel.sv
module rom_emu_bank_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic swap_req_i,
  input  logic eng_idle_i,
  input  logic tgt_idle_i,
  output logic active_o,
  output logic pend_o,
  output logic done_o
);

  logic active_q, pend_q, done_q, fire;

  assign fire = pend_q && eng_idle_i && tgt_idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= fire;
      if (fire) active_q <= ~active_q;
      // request on the swap edge re-arms for the next swap
      pend_q <= (pend_q && !fire) || swap_req_i;
    end
  end

  assign active_o = active_q;
  assign pend_o   = pend_q;
  assign done_o   = done_q;

endmodule

// File: rtl/rom_emu_ctrl.sv
module rom_emu_ctrl
  import rom_emu_pkg::*;
#(
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned WR_PULSE    = 3,
  parameter int unsigned RD_WAIT     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [ADDR_W-1:0]            tgt_addr_i,
  input  logic                         tgt_ce_ni,
  input  logic                         tgt_oe_ni,
  output logic [DATA_W-1:0]            tgt_data_o,
  output logic                         tgt_drive_o,
  input  logic [ADDR_W-1:0]            host_addr_i,
  input  logic [DATA_W-1:0]            host_wdata_i,
  input  logic                         host_wr_i,
  input  logic                         host_rd_i,
  input  logic                         host_swap_i,
  output logic                         host_ready_o,
  output logic [DATA_W-1:0]            host_rdata_o,
  output logic                         host_rvalid_o,
  output logic                         swap_done_o,
  output logic                         active_bank_o,
  output logic [1:0][ADDR_W-1:0]       sram_addr_o,
  output logic [1:0][DATA_W-1:0]       sram_wdata_o,
  input  logic [1:0][DATA_W-1:0]       sram_rdata_i,
  output logic [1:0]                   sram_ce_no,
  output logic [1:0]                   sram_oe_no,
  output logic [1:0]                   sram_we_no
);

  logic              tgt_idle, tgt_idle_s;
  logic              eng_idle, swap_pend, active;
  logic [ADDR_W-1:0] sh_addr;
  logic [DATA_W-1:0] sh_wdata;
  sram_ctl_t         sh_ctl;

  assign tgt_idle = tgt_ce_ni | tgt_oe_ni;

  rom_emu_sync #(.STAGES(SYNC_STAGES)) u_tgt_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tgt_idle),
    .q_o   (tgt_idle_s)
  );

  rom_emu_bank_sel u_bank_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .swap_req_i(host_swap_i),
    .eng_idle_i(eng_idle),
    .tgt_idle_i(tgt_idle_s),
    .active_o  (active),
    .pend_o    (swap_pend),
    .done_o    (swap_done_o)
  );

  rom_emu_host_eng #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .WR_PULSE(WR_PULSE),
    .RD_WAIT (RD_WAIT)
  ) u_host_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (swap_pend),
    .addr_i    (host_addr_i),
    .wdata_i   (host_wdata_i),
    .wr_i      (host_wr_i),
    .rd_i      (host_rd_i),
    .sh_rdata_i(sram_rdata_i[~active]),
    .idle_o    (eng_idle),
    .ready_o   (host_ready_o),
    .rdata_o   (host_rdata_o),
    .rvalid_o  (host_rvalid_o),
    .sh_addr_o (sh_addr),
    .sh_wdata_o(sh_wdata),
    .sh_ctl_o  (sh_ctl)
  );

  // per-bank role mux: active bank follows target pins, shadow follows host engine
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic is_act;
    assign is_act = (active == 1'(b));
    always_comb begin
      if (is_act) begin
        sram_addr_o[b]  = tgt_addr_i;
        sram_wdata_o[b] = '0;
        sram_ce_no[b]   = tgt_ce_ni;
        sram_oe_no[b]   = tgt_oe_ni;
        sram_we_no[b]   = 1'b1;
      end else begin
        sram_addr_o[b]  = sh_addr;
        sram_wdata_o[b] = sh_wdata;
        sram_ce_no[b]   = sh_ctl.ce_n;
        sram_oe_no[b]   = sh_ctl.oe_n;
        sram_we_no[b]   = sh_ctl.we_n;
      end
    end
  end

  assign tgt_drive_o   = !tgt_ce_ni && !tgt_oe_ni;
  assign tgt_data_o    = tgt_drive_o ? sram_rdata_i[active] : '0;
  assign active_bank_o = active;

  assert_active_bank_read_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_we_no[active_bank_o]);

  assert_swap_only_when_safe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_bank_o != $past(active_bank_o)) |-> $past(eng_idle && tgt_idle_s));

  assert_pend_blocks_host_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_pend |-> !host_ready_o);

  assert_done_follows_toggle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_done_o |-> (active_bank_o != $past(active_bank_o)));

  assert_shadow_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ready_o |-> (sram_ce_no[~active_bank_o] && sram_we_no[~active_bank_o]));

endmodule

// File: tb/rom_emu_ctrl_tb_top.sv
module rom_emu_ctrl_tb_top;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int WRP = 3;
  localparam int RDW = 2;
  localparam int SYN = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] tgt_addr = '0;
  logic tgt_ce_n = 1'b1, tgt_oe_n = 1'b1;
  logic [DW-1:0] tgt_data;
  logic tgt_drive;
  logic [AW-1:0] h_addr = '0;
  logic [DW-1:0] h_wdata = '0;
  logic h_wr = 1'b0, h_rd = 1'b0, h_swap = 1'b0;
  logic h_ready, h_rvalid, swap_done, act_bank;
  logic [DW-1:0] h_rdata;
  logic [1:0][AW-1:0] s_addr;
  logic [1:0][DW-1:0] s_wdata;
  logic [1:0][DW-1:0] s_rdata;
  logic [1:0] s_ce_n, s_oe_n, s_we_n;

  rom_emu_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WR_PULSE(WRP), .RD_WAIT(RDW), .SYNC_STAGES(SYN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tgt_addr_i(tgt_addr), .tgt_ce_ni(tgt_ce_n), .tgt_oe_ni(tgt_oe_n),
    .tgt_data_o(tgt_data), .tgt_drive_o(tgt_drive),
    .host_addr_i(h_addr), .host_wdata_i(h_wdata), .host_wr_i(h_wr), .host_rd_i(h_rd),
    .host_swap_i(h_swap), .host_ready_o(h_ready), .host_rdata_o(h_rdata),
    .host_rvalid_o(h_rvalid), .swap_done_o(swap_done), .active_bank_o(act_bank),
    .sram_addr_o(s_addr), .sram_wdata_o(s_wdata), .sram_rdata_i(s_rdata),
    .sram_ce_no(s_ce_n), .sram_oe_no(s_oe_n), .sram_we_no(s_we_n)
  );

  // SRAM models
  logic [DW-1:0] mem0 [DEPTH];
  logic [DW-1:0] mem1 [DEPTH];
  always @(posedge s_we_n[0]) if (s_ce_n[0] === 1'b0) mem0[s_addr[0]] <= s_wdata[0];
  always @(posedge s_we_n[1]) if (s_ce_n[1] === 1'b0) mem1[s_addr[1]] <= s_wdata[1];
  always_comb begin
    s_rdata[0] = (!s_ce_n[0] && !s_oe_n[0]) ? mem0[s_addr[0]] : '0;
    s_rdata[1] = (!s_ce_n[1] && !s_oe_n[1]) ? mem1[s_addr[1]] : '0;
  end

  // reference model
  int exp_mem [2][DEPTH];
  int m_active, m_pend, m_done, m_rvalid, m_rdata, m_busy, m_wr_op, m_addr;
  int m_hist [SYN];
  int n_cmp = 0, n_fail = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_pend = 0; m_done = 0; m_rvalid = 0; m_rdata = 0;
      m_busy = 0; m_wr_op = 0; m_addr = 0;
      for (int i = 0; i < SYN; i++) m_hist[i] = 0;
    end else begin
      int old_busy, ready, exec;
      old_busy = m_busy;
      ready = (m_busy == 0 && m_pend == 0);
      exec = (m_pend != 0 && m_busy == 0 && m_hist[SYN-1] != 0);
      m_done = exec;
      m_rvalid = 0;
      if (old_busy > 0) begin
        m_busy--;
        if (m_busy == 0 && !m_wr_op) begin
          m_rvalid = 1;
          m_rdata = exp_mem[1 - m_active][m_addr];
        end
      end else if (ready && h_wr) begin
        m_wr_op = 1; m_busy = WRP + 1; m_addr = int'(h_addr);
        exp_mem[1 - m_active][h_addr] = int'(h_wdata);
      end else if (ready && h_rd) begin
        m_wr_op = 0; m_busy = RDW; m_addr = int'(h_addr);
      end
      if (exec) m_active = 1 - m_active;
      m_pend = ((m_pend != 0 && !exec) || h_swap) ? 1 : 0;
      for (int i = SYN - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = (tgt_ce_n || tgt_oe_n) ? 1 : 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int sh, drv;
    sh = 1 - m_active;
    drv = (!tgt_ce_n && !tgt_oe_n) ? 1 : 0;
    chk("R9 active bank", int'(act_bank), m_active);
    chk("R9 swap done", int'(swap_done), m_done);
    chk("R7 ready", int'(h_ready), (m_busy == 0 && m_pend == 0) ? 1 : 0);
    chk("R6 rvalid", int'(h_rvalid), m_rvalid);
    if (m_rvalid != 0) chk("R6 rdata", int'(h_rdata), m_rdata);
    chk("R3 drive", int'(tgt_drive), drv);
    chk("R2 target data", int'(tgt_data), drv ? exp_mem[m_active][tgt_addr] : 0);
    chk("R4 active we", int'(s_we_n[m_active]), 1);
    chk("R4 active ce", int'(s_ce_n[m_active]), int'(tgt_ce_n));
    chk("R4 active oe", int'(s_oe_n[m_active]), int'(tgt_oe_n));
    chk("R4 active addr", int'(s_addr[m_active]), int'(tgt_addr));
    if (m_busy == 0) begin
      chk("R10 shadow ce", int'(s_ce_n[sh]), 1);
      chk("R10 shadow oe", int'(s_oe_n[sh]), 1);
      chk("R10 shadow we", int'(s_we_n[sh]), 1);
    end else begin
      chk("R5 shadow ce", int'(s_ce_n[sh]), 0);
      chk("R5 shadow we", int'(s_we_n[sh]), (m_wr_op != 0 && m_busy > 1) ? 0 : 1);
      chk("R6 shadow oe", int'(s_oe_n[sh]), (m_wr_op == 0) ? 0 : 1);
      chk("R5 shadow addr", int'(s_addr[sh]), m_addr);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  function automatic bit m_ready();
    return (m_busy == 0 && m_pend == 0);
  endfunction

  task automatic host_write(int a, int d);
    while (!m_ready()) step();
    h_wr = 1'b1; h_addr = AW'(a); h_wdata = DW'(d);
    step();
    h_wr = 1'b0;
  endtask

  task automatic host_read(int a);
    while (!m_ready()) step();
    h_rd = 1'b1; h_addr = AW'(a);
    step();
    h_rd = 1'b0;
  endtask

  task automatic host_swap_req();
    h_swap = 1'b1;
    step();
    h_swap = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem0[i] = '0; mem1[i] = '0; exp_mem[0][i] = 0; exp_mem[1][i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 active after reset", int'(act_bank), 0);
    chk("R1 ready after reset", int'(h_ready), 1);
    chk("R1 done after reset", int'(swap_done), 0);
    chk("R1 rvalid after reset", int'(h_rvalid), 0);

    // R3 enable combinations on an empty bank
    tgt_ce_n = 1'b0; tgt_oe_n = 1'b1; step();
    tgt_ce_n = 1'b1; tgt_oe_n = 1'b0; step();
    tgt_ce_n = 1'b0; tgt_oe_n = 1'b0; tgt_addr = 8'h10; step();

    // R5 load shadow, boundary addresses included; target keeps fetching
    host_write(0, 8'hA5);
    host_write(DEPTH - 1, 8'h5A);
    for (int i = 1; i < 12; i++) begin
      tgt_addr = AW'(i * 7);
      host_write(i * 13, (i * 37 + 3) & 8'hFF);
    end
    // R5 strobe while busy is ignored
    h_wr = 1'b1; h_addr = 8'h40; h_wdata = 8'hEE; step();
    h_wr = 1'b1; step();
    h_wr = 1'b0;
    // R6 read back, incl. simultaneous wr+rd priority
    host_read(0);
    host_read(DEPTH - 1);
    host_read(26);
    while (!m_ready()) step();
    h_wr = 1'b1; h_rd = 1'b1; h_addr = 8'h77; h_wdata = 8'h3C; step();
    h_wr = 1'b0; h_rd = 1'b0;
    host_read(8'h77);
    repeat (4) step();

    // R8 swap held off while target fetches continuously
    tgt_ce_n = 1'b0; tgt_oe_n = 1'b0;
    repeat (4) step();
    host_swap_req();
    repeat (10) step();
    chk("R8 no swap during fetch", int'(act_bank), 0);
    tgt_oe_n = 1'b1;
    repeat (4) step();
    chk("R8 swap after fetch ends", int'(act_bank), 1);
    tgt_oe_n = 1'b0; tgt_addr = 8'h00; step();
    chk("R2 new image visible", int'(tgt_data), 8'hA5);
    tgt_addr = 8'hFF; step();
    chk("R2 new image top byte", int'(tgt_data), 8'h5A);
    tgt_ce_n = 1'b1; tgt_oe_n = 1'b1;

    // R11 repeated requests merge into one swap
    host_swap_req();
    host_swap_req();
    repeat (8) step();
    chk("R11 merged swap", int'(act_bank), 0);

    // R8 swap requested during a host write waits for engine
    host_write(5, 8'h99);
    repeat (2) step();
    host_swap_req();
    repeat (8) step();
    chk("R8 swap after write", int'(act_bank), 1);

    // random mixed traffic
    for (int c = 0; c < 4000; c++) begin
      tgt_addr = AW'($urandom);
      tgt_ce_n = ($urandom_range(0, 9) < 4);
      tgt_oe_n = ($urandom_range(0, 9) < 4);
      h_addr   = AW'($urandom);
      h_wdata  = DW'($urandom);
      h_wr     = ($urandom_range(0, 9) < 3);
      h_rd     = ($urandom_range(0, 9) < 2);
      h_swap   = ($urandom_range(0, 99) < 3);
      step();
    end
    h_wr = 1'b0; h_rd = 1'b0; h_swap = 1'b0; tgt_ce_n = 1'b1;
    repeat (10) step();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

endmodule